// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block settles one two-byte conditional relative branch of an 8-bit processor that has a 16-bit program counter. The caller gives it the opcode byte, the signed 8-bit displacement, the address where the opcode sits, and the four condition flags (negative, overflow, carry, zero). It returns whether the branch is taken, the next program counter value, and how many machine cycles the branch costs. The block never changes a flag. It does not fetch bytes from memory.

The block is a small registered unit driven by a start/done handshake. A controller has three named states. `ST_IDLE` waits for `start`. On `start` it captures the operands and moves to `ST_CALC` (transition *accept*). `ST_CALC` evaluates the condition, the target and the page crossing, loads the result registers and moves to `ST_DONE` (transition *resolve*). `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE` (transition *release*). The results stay on the outputs until the next `done`. An opcode that is not a branch raises `bad_op` and is treated as a branch that is not taken.

Top module: `branch_resolver`

## Requirements
- R1: A `start` that arrives while the block is idle is accepted at that clock edge. `busy` is then high for two cycles, and `done` is high for exactly the second of those two cycles. A `start` that arrives while `busy` is high is ignored.
- R2: A valid branch opcode has bits 4:0 equal to 10000. Bits 7:6 choose the flag: 00 is N, 01 is V, 10 is C, 11 is Z. Bit 5 is the flag value that makes the branch taken. The eight codes are 0x10, 0x30, 0x50, 0x70, 0x90, 0xB0, 0xD0 and 0xF0.
- R3: `taken` is 1 exactly when the chosen flag equals opcode bit 5.
- R4: The fall-through address is the opcode address plus 2. A taken branch sets `next_pc` to the fall-through address plus the sign-extended displacement, so 0x06 lands 8 bytes after the opcode and 0xFA lands 4 bytes before it. A branch that is not taken sets `next_pc` to the fall-through address.
- R5: A branch that is not taken costs `cycles` = 2.
- R6: A taken branch whose target has the same high byte as the fall-through address costs 3. A displacement of 0 therefore always costs 3.
- R7: A taken branch whose target has a different high byte from the fall-through address costs 4.
- R8: All address arithmetic wraps modulo 65536.
- R9: A non-branch opcode sets `bad_op`=1, `taken`=0, `next_pc` to the opcode address plus 2, and `cycles`=2. A valid branch clears `bad_op`.
- R10: After reset, `busy`, `done`, `taken` and `bad_op` are 0, `next_pc` is 0x0000, and `cycles` is 0.
- R11: The result outputs hold their values from one `done` until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to resolve one branch |
| opcode | input | 8 | Branch opcode byte |
| disp | input | 8 | Signed displacement |
| op_addr | input | 16 | Address of the opcode byte |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| taken | output | 1 | The branch is taken |
| next_pc | output | 16 | Next program counter value |
| cycles | output | 3 | Machine cycles the branch costs |
| bad_op | output | 1 | The opcode was not a branch |

## Verification
A fault in the controller state appears at the ports within two cycles of `start`. It can show as a missing `done`, a `done` that comes a cycle early or late, or a `done` wider than one cycle. It can also show as a second request that is accepted while `busy` is high, which leaves the second operands on the outputs. A fault in the captured operands or in the page-crossing logic appears at the same `done` as a wrong `next_pc` or `cycles` value. The forward page crossing, the backward page crossing and the wrap from 0xFFFF to 0x0000 make each kind of fault visible. A fault in holding the results appears as outputs that change between two `done` pulses.

// File: rtl/branch_resolver_pkg.sv
package branch_resolver_pkg;
    localparam int OP_W   = 8;
    localparam int ADDR_W = 16;
    localparam int CYC_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } fsm_state_t;

    typedef enum logic [1:0] {
        SEL_N = 2'b00,
        SEL_V = 2'b01,
        SEL_C = 2'b10,
        SEL_Z = 2'b11
    } flag_sel_t;
endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import branch_resolver_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic [OPW-1:0] op,
    input  logic           fn,
    input  logic           fv,
    input  logic           fc,
    input  logic           fz,
    output logic           is_branch,
    output logic           cond_true
);
    flag_sel_t sel;
    logic      picked;

    // Bits 4:0 of a branch opcode read 10000.
    assign is_branch = (op[4:0] == 5'b10000);
    assign sel       = flag_sel_t'(op[OPW-1 -: 2]);

    always_comb begin
        unique case (sel)
            SEL_N: picked = fn;
            SEL_V: picked = fv;
            SEL_C: picked = fc;
            SEL_Z: picked = fz;
        endcase
    end

    // Bit 5 holds the flag value that takes the branch.
    assign cond_true = is_branch && (picked == op[5]);
endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] offs,
    output logic [AW-1:0] fall_thru,
    output logic [AW-1:0] target,
    output logic          page_cross
);
    localparam int PAGE_BITS = 8;
    localparam int HI_W      = AW - PAGE_BITS;

    logic [AW-1:0] offs_ext;

    assign offs_ext   = {{(AW-DW){offs[DW-1]}}, offs};
    assign fall_thru  = base + AW'(2);
    assign target     = fall_thru + offs_ext;
    assign page_cross = (target[AW-1 -: HI_W] != fall_thru[AW-1 -: HI_W]);
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import branch_resolver_pkg::*;
#(
    parameter int OPW = OP_W,
    parameter int AW  = ADDR_W,
    parameter int CW  = CYC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] opcode,
    input  logic [OPW-1:0] disp,
    input  logic [AW-1:0]  op_addr,
    input  logic           flag_n,
    input  logic           flag_v,
    input  logic           flag_c,
    input  logic           flag_z,
    output logic           busy,
    output logic           done,
    output logic           taken,
    output logic [AW-1:0]  next_pc,
    output logic [CW-1:0]  cycles,
    output logic           bad_op
);
    localparam logic [CW-1:0] CYC_BASE = CW'(2);

    fsm_state_t     state_q, state_d;
    logic [OPW-1:0] op_q, disp_q;
    logic [AW-1:0]  addr_q;
    logic [3:0]     flags_q;

    logic          is_br, cond_ok, crosses;
    logic [AW-1:0] ft_addr, tgt_addr;

    branch_cond_eval #(.OPW(OPW)) u_cond (
        .op        (op_q),
        .fn        (flags_q[3]),
        .fv        (flags_q[2]),
        .fc        (flags_q[1]),
        .fz        (flags_q[0]),
        .is_branch (is_br),
        .cond_true (cond_ok)
    );

    branch_target_calc #(.AW(AW), .DW(OPW)) u_tgt (
        .base       (addr_q),
        .offs       (disp_q),
        .fall_thru  (ft_addr),
        .target     (tgt_addr),
        .page_cross (crosses)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CALC;   // accept
            ST_CALC: state_d = ST_DONE;              // resolve
            ST_DONE: state_d = ST_IDLE;              // release
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Operand capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            disp_q  <= '0;
            addr_q  <= '0;
            flags_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            op_q    <= opcode;
            disp_q  <= disp;
            addr_q  <= op_addr;
            flags_q <= {flag_n, flag_v, flag_c, flag_z};
        end
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            taken   <= 1'b0;
            next_pc <= '0;
            cycles  <= '0;
            bad_op  <= 1'b0;
        end else begin
            done <= (state_q == ST_CALC);
            if (state_q == ST_CALC) begin
                taken   <= cond_ok;
                bad_op  <= !is_br;
                next_pc <= cond_ok ? tgt_addr : ft_addr;
                cycles  <= CYC_BASE + CW'(cond_ok) + CW'(cond_ok && crosses);
            end
        end
    end

    assign busy = (state_q != ST_IDLE);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_ACCEPT_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> ##1 done); // R1
    AST_NOT_TAKEN_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken) |-> (cycles == CYC_BASE)); // R5
    AST_TAKEN_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (done && taken) |-> (cycles == CW'(3) || cycles == CW'(4))); // R6
    AST_BAD_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bad_op) |-> !taken); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(done) && !done) |-> $stable(next_pc)); // R11
endmodule

// File: tb/branch_resolver_tb.sv
module branch_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00, disp = 8'h00;
    logic [15:0] op_addr = 16'h0000;
    logic        fn = 0, fv = 0, fc = 0, fz = 0;
    logic        busy, done, taken, bad_op;
    logic [15:0] next_pc;
    logic [2:0]  cycles;

    int n_chk = 0, n_bad = 0;
    bit summary_done = 0;

    always #5 clk = ~clk;

    branch_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .disp(disp),
        .op_addr(op_addr), .flag_n(fn), .flag_v(fv), .flag_c(fc), .flag_z(fz),
        .busy(busy), .done(done), .taken(taken), .next_pc(next_pc),
        .cycles(cycles), .bad_op(bad_op)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    endtask

    // Expected-result model, written from the requirements.
    task automatic model(input logic [7:0] op, input logic [7:0] d, input logic [15:0] a,
                         input logic [3:0] f, output bit e_tk, output int e_pc,
                         output int e_cy, output bit e_bad);
        int  ft, tg, sd;
        bit  flag;
        e_bad = (op[4:0] != 5'b10000);
        case (op[7:6])
            2'b00: flag = f[3];
            2'b01: flag = f[2];
            2'b10: flag = f[1];
            default: flag = f[0];
        endcase
        e_tk = !e_bad && (flag == op[5]);
        ft = (int'(a) + 2) % 65536;
        sd = (d >= 8'h80) ? int'(d) - 256 : int'(d);
        tg = (ft + sd + 65536) % 65536;
        e_pc = e_tk ? tg : ft;
        e_cy = !e_tk ? 2 : (((tg / 256) != (ft / 256)) ? 4 : 3);
    endtask

    // Drive one request, wait for done, compare everything.
    task automatic run(input string req, input logic [7:0] op, input logic [7:0] d,
                       input logic [15:0] a, input logic [3:0] f);
        bit e_tk, e_bad; int e_pc, e_cy; bit seen = 0;
        model(op, d, a, f, e_tk, e_pc, e_cy, e_bad);
        @(negedge clk);
        opcode = op; disp = d; op_addr = a; {fn, fv, fc, fz} = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        check("R1", "done seen", int'(seen), 1);
        check(req, "taken", int'(taken), int'(e_tk));
        check(req, "next_pc", int'(next_pc), e_pc);
        check(req, "cycles", int'(cycles), e_cy);
        check(req, "bad_op", int'(bad_op), int'(e_bad));
    endtask

    task automatic t_reset();
        check("R10", "busy", int'(busy), 0);
        check("R10", "done", int'(done), 0);
        check("R10", "taken", int'(taken), 0);
        check("R10", "next_pc", int'(next_pc), 0);
        check("R10", "cycles", int'(cycles), 0);
        check("R10", "bad_op", int'(bad_op), 0);
    endtask

    task automatic t_all_codes();
        for (int k = 0; k < 8; k++) begin
            logic [7:0] op = 8'(k * 32 + 16);
            logic [3:0] hit = op[5] ? (4'b1000 >> (k / 2)) : ~(4'b1000 >> (k / 2));
            run("R3", op, 8'h10, 16'h2000, hit);   // R2 taken
            run("R3", op, 8'h10, 16'h2000, ~hit);  // R2 not taken, R5
        end
    endtask

    task automatic t_offsets();
        run("R4", 8'hF0, 8'h06, 16'h3040, 4'b0001);  // 8 bytes past opcode
        check("R4", "plus 8", int'(next_pc), 16'h3048);
        run("R4", 8'hF0, 8'hFA, 16'h3040, 4'b0001);  // 4 bytes before opcode
        check("R4", "minus 4", int'(next_pc), 16'h303C);
        run("R6", 8'h90, 8'h00, 16'h41FE, 4'b0000);  // zero displacement
        check("R6", "disp0 cost", int'(cycles), 3);
    endtask

    task automatic t_pages();
        run("R7", 8'hB0, 8'h20, 16'h10F0, 4'b0010);
        check("R7", "fwd cross", int'(cycles), 4);
        run("R7", 8'h30, 8'hF0, 16'h1102, 4'b1000);
        check("R7", "back cross", int'(cycles), 4);
        run("R6", 8'h50, 8'h7F, 16'h5000, 4'b0000);
        check("R6", "same page", int'(cycles), 3);
    endtask

    task automatic t_wrap();
        run("R8", 8'hD0, 8'h05, 16'hFFFD, 4'b0000);
        check("R8", "wrap up", int'(next_pc), 16'h0004);
        run("R8", 8'h70, 8'h80, 16'h0010, 4'b0100);
        check("R8", "wrap down", int'(next_pc), 16'hFF92);
        run("R8", 8'h10, 8'h00, 16'hFFFF, 4'b1000);  // not taken, fall-through wraps
        check("R8", "ft wrap", int'(next_pc), 16'h0001);
    endtask

    task automatic t_bad_ops();
        run("R9", 8'h20, 8'h10, 16'h7000, 4'b1111);
        check("R9", "bad pc", int'(next_pc), 16'h7002);
        run("R9", 8'h11, 8'h10, 16'h7000, 4'b0000);
        run("R9", 8'hEA, 8'h80, 16'hFFFE, 4'b0000);
        run("R9", 8'hF0, 8'h01, 16'h0100, 4'b0001);  // valid again clears bad_op
    endtask

    task automatic t_busy_ignore();
        int pulses = 0;
        @(negedge clk);
        opcode = 8'hF0; disp = 8'h02; op_addr = 16'h6000; {fn, fv, fc, fz} = 4'b0001; start = 1'b1;
        @(negedge clk);
        check("R1", "busy after accept", int'(busy), 1);
        opcode = 8'h20; op_addr = 16'h9000; disp = 8'h40;  // second request while busy
        @(negedge clk);
        check("R1", "done on 2nd cycle", int'(done), 1);
        check("R1", "first result kept", int'(next_pc), 16'h6004);
        pulses += int'(done);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pulses += int'(done);
        end
        check("R1", "single done", pulses, 1);
        check("R11", "hold pc", int'(next_pc), 16'h6004);
        check("R11", "hold cycles", int'(cycles), 3);
        check("R1", "idle again", int'(busy), 0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_all_codes();
        t_offsets();
        t_pages();
        t_wrap();
        t_bad_ops();
        t_busy_ignore();
        finish_run();
    end
endmodule